// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter

This block decides which of several interrupt sources may interrupt the processor next. Each ordinary source raises a request line together with a 3-bit priority level. The block compares every active request against a current priority level (CPL) held in an 8-bit control register. Level 0 is the most urgent and level 7 the least. A separate top-level request can be accepted even when ordinary interrupts are disabled. The block presents a combinational grant, made of a valid flag, a top-level flag and a source index. The core answers with an acknowledge strobe when it starts the handler and a return strobe when the handler ends.

The block has two arbitration modes. In nested mode, every acknowledge pushes the interrupted CPL onto an internal stack, and each return pops it back. A chain of handlers at ever more urgent levels therefore unwinds in order. In concurrent mode nothing is saved, and a return always drops the CPL back to the idle level 7. The control register is also writable through a simple write port. A write to the interrupt-enable bit is refused while any request is pending. The most significant bit is a plain enable that the block stores and presents for neighbouring timers.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset the control register reads 87h: enable bit 7 is 1, pending bit 6 is 0, mask-mode bit 5 is 0, interrupt-enable bit 4 is 0, mode bit 3 is 0 and CPL bits 2:0 are 111. No grant is valid.
- R2: A write loads all eight control bits from the write data: bit 7 global enable, bit 6 top pending, bit 5 top mask mode, bit 4 interrupt enable, bit 3 mode (0 concurrent, 1 nested) and bits 2:0 CPL. The value is visible on the next cycle. A write in the same cycle as an accepted acknowledge or a return is discarded.
- R3: An ordinary request is eligible only when the interrupt-enable bit is 1 and its level is numerically lower than the CPL.
- R4: Among eligible ordinary requests, the lowest level wins. On equal levels the lowest source index wins. An eligible top-level request wins over all of them and reports index 0.
- R5: An acknowledge while a grant is valid clears the interrupt-enable bit. It also loads the CPL with the granted level, which is 000 for a top-level grant. An acknowledge with no valid grant changes nothing.
- R6: In nested mode an acknowledge saves the previous CPL, and each return restores the most recently saved level. At least seven saved levels are kept. A return with nothing saved sets the CPL to 111.
- R7: In concurrent mode an acknowledge saves nothing, and a return sets the CPL to 111.
- R8: A return that does not coincide with an acknowledge sets the interrupt-enable bit.
- R9: A top-level request input sets the pending bit, and a software write of 1 to bit 6 also sets it. The acknowledge of a top-level grant clears the pending bit.
- R10: With mask mode 0, a pending top-level request is granted regardless of the interrupt-enable bit. With mask mode 1, it is granted only while the interrupt-enable bit is 1.
- R11: While any request line is high or the pending bit is set, a write leaves the interrupt-enable bit unchanged and still updates the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Ordinary request lines |
| req_lvl_i | input | NUM_SRC*3 | Level of source i in bits 3i+2:3i |
| top_req_i | input | 1 | Top-level request |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| ack_i | input | 1 | Acknowledge of the current grant |
| ret_i | input | 1 | Return from the running handler |
| grant_valid_o | output | 1 | A source may interrupt |
| grant_top_o | output | 1 | The grant belongs to the top-level request |
| grant_idx_o | output | $clog2(NUM_SRC) | Index of the granted source |
| ctrl_o | output | 8 | Control register contents |

## Verification
Suppose the saved-level stack holds a wrong entry or a wrong depth. Nothing shows at the ports until the matching return. The CPL read back in the next cycle is then wrong, and a later request may be granted or blocked wrongly. The bench therefore nests two handlers and unwinds them fully, then returns once more on an empty stack. A wrong interrupt-enable or pending bit shows at once, because the grant outputs are combinational. A request that should be blocked would appear as a grant in the same cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic gcen;   // stored global enable for neighbouring timers
    logic tlp;    // top-level request pending
    logic tli;    // top-level mask mode
    logic ien;    // interrupt enable
    logic iam;    // 1 nested, 0 concurrent
    lvl_t cpl;    // current priority level
  } ctrl_t;

  localparam ctrl_t CTRL_RST  = 8'h87;
  localparam lvl_t  LVL_IDLE  = '1;
  localparam lvl_t  LVL_TOP   = '0;

endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat_i,
  input  ctrl_t                    ctrl_i,
  output logic                     valid_o,
  output logic                     top_o,
  output logic [IDX_W-1:0]         idx_o,
  output lvl_t                     lvl_o
);

  lvl_t             lvl_a [NUM_SRC];
  logic             best_found;
  lvl_t             best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             top_ok;
  logic             norm_ok;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_split
    assign lvl_a[g] = lvl_flat_i[g*LVL_W +: LVL_W];
  end

  always_comb begin
    best_found = 1'b0;
    best_lvl   = LVL_IDLE;
    best_idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (lvl_a[i] < ctrl_i.cpl) &&
          (!best_found || (lvl_a[i] < best_lvl))) begin
        best_found = 1'b1;
        best_lvl   = lvl_a[i];
        best_idx   = IDX_W'(i);
      end
    end
  end

  assign top_ok  = ctrl_i.tlp & (~ctrl_i.tli | ctrl_i.ien);
  assign norm_ok = ctrl_i.ien & best_found;

  assign valid_o = top_ok | norm_ok;
  assign top_o   = top_ok;
  assign idx_o   = top_ok ? '0 : best_idx;
  assign lvl_o   = top_ok ? LVL_TOP : best_lvl;

  // R3: an ordinary grant must beat the held level and needs the enable
  p_grant_beats_cpl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !top_o) |-> (ctrl_i.ien && (lvl_o < ctrl_i.cpl) && req_i[idx_o]));

  // R10: masked top-level request never granted while disabled
  p_top_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.tli && !ctrl_i.ien) |-> !top_o);

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output lvl_t top_o,
  output logic empty_o
);

  lvl_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             do_push;
  logic             do_pop;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign do_push = push_i & (cnt_q < CNT_W'(DEPTH));
  assign do_pop  = pop_i & (cnt_q != '0);
  assign wr_ptr  = cnt_q[PTR_W-1:0];
  assign rd_ptr  = PTR_W'(cnt_q - CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (do_push)     cnt_n = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr] <= push_lvl_i;
  end

  assign top_o   = mem_q[rd_ptr];
  assign empty_o = (cnt_q == '0);

  // R6: a saved level is readable right after it is pushed
  p_push_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && empty_o) |=> (!empty_o && top_o == $past(push_lvl_i)));

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               top_req_i,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_data_i,
  input  logic               ack_i,
  input  logic               ret_i,
  input  logic               g_valid_i,
  input  logic               g_top_i,
  input  lvl_t               g_lvl_i,
  input  lvl_t               stk_top_i,
  input  logic               stk_empty_i,
  output logic               push_o,
  output lvl_t               push_lvl_o,
  output logic               pop_o,
  output ctrl_t              ctrl_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_n;
  ctrl_t wr_val;
  logic  ack_take;
  logic  pending;

  assign ack_take   = ack_i & g_valid_i;
  assign pending    = (|req_i) | ctrl_q.tlp;
  assign wr_val     = ctrl_t'(wr_data_i);
  assign push_lvl_o = ctrl_q.cpl;

  always_comb begin
    ctrl_n = ctrl_q;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (wr_en_i && !ack_take && !ret_i) begin
      ctrl_n = wr_val;
      if (pending) ctrl_n.ien = ctrl_q.ien;
    end
    if (ack_take) begin
      ctrl_n.ien = 1'b0;
      ctrl_n.cpl = g_lvl_i;
      if (g_top_i) ctrl_n.tlp = 1'b0;
      push_o = ctrl_q.iam;
    end else if (ret_i) begin
      ctrl_n.ien = 1'b1;
      if (ctrl_q.iam && !stk_empty_i) begin
        ctrl_n.cpl = stk_top_i;
        pop_o      = 1'b1;
      end else begin
        ctrl_n.cpl = LVL_IDLE;
      end
    end
    if (top_req_i) ctrl_n.tlp = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_n;
  end

  assign ctrl_o = ctrl_q;

  // R5: an accepted acknowledge disables further ordinary interrupts
  p_ack_clears_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && g_valid_i) |=> !ctrl_q.ien);

  // R8: a lone return re-enables interrupts
  p_ret_sets_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i) |=> ctrl_q.ien);

  // R7: concurrent-mode return goes back to the idle level
  p_conc_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i && !ctrl_q.iam) |=> (ctrl_q.cpl == LVL_IDLE));

  // R9: a top-level request is always latched
  p_top_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    top_req_i |=> ctrl_q.tlp);

  // R11: enable bit guarded while anything is pending
  p_ien_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && pending && !ack_i && !ret_i) |=> $stable(ctrl_q.ien));

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int STK_DEPTH = 8,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     req_i,
  input  logic [NUM_SRC*3-1:0]   req_lvl_i,
  input  logic                   top_req_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   ack_i,
  input  logic                   ret_i,
  output logic                   grant_valid_o,
  output logic                   grant_top_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic [7:0]             ctrl_o
);

  ctrl_t ctrl;
  lvl_t  g_lvl;
  logic  push;
  logic  pop;
  lvl_t  push_lvl;
  lvl_t  stk_top;
  logic  stk_empty;

  irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .lvl_flat_i (req_lvl_i),
    .ctrl_i     (ctrl),
    .valid_o    (grant_valid_o),
    .top_o      (grant_top_o),
    .idx_o      (grant_idx_o),
    .lvl_o      (g_lvl)
  );

  irq_ctrl_reg #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .top_req_i   (top_req_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .g_valid_i   (grant_valid_o),
    .g_top_i     (grant_top_o),
    .g_lvl_i     (g_lvl),
    .stk_top_i   (stk_top),
    .stk_empty_i (stk_empty),
    .push_o      (push),
    .push_lvl_o  (push_lvl),
    .pop_o       (pop),
    .ctrl_o      (ctrl)
  );

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_lvl_i (push_lvl),
    .pop_i      (pop),
    .top_o      (stk_top),
    .empty_o    (stk_empty)
  );

  assign ctrl_o = ctrl;

endmodule

// File: tb/sim_irq_level_arbiter.sv
`timescale 1ns/1ps
module sim_irq_level_arbiter;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N*3-1:0] lvl;
  logic         top_req, wr_en, ack, ret;
  logic [7:0]   wr_data;
  logic         g_valid, g_top;
  logic [2:0]   g_idx;
  logic [7:0]   ctrl;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 0;

  always #2 clk = ~clk;

  irq_level_arbiter #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_lvl_i(lvl),
    .top_req_i(top_req), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ack_i(ack), .ret_i(ret), .grant_valid_o(g_valid),
    .grant_top_o(g_top), .grant_idx_o(g_idx), .ctrl_o(ctrl));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic set_req(input int i, input int l);
    req[i] = 1'b1;
    lvl[i*3 +: 3] = 3'(l);
  endtask

  task automatic clr_req();
    req = '0;
    lvl = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl after reset", ctrl, 8'h87);
    chk("R1 no grant after reset", g_valid, 0);
    wr(8'h9F);
    chk("R2 write nested enabled", ctrl, 8'h9F);
  endtask

  task automatic t_pick();
    set_req(2, 3); set_req(5, 1); set_req(6, 1); #0.5;
    chk("R4 grant valid", g_valid, 1);
    chk("R4 tie lowest index", g_idx, 5);
    chk("R4 not top", g_top, 0);
    clr_req(); set_req(2, 7); #0.5;
    chk("R3 equal level blocked", g_valid, 0);
    clr_req(); #0.5;
  endtask

  task automatic t_nested();
    set_req(2, 3); #0.5;
    do_ack();
    chk("R5 ack clears ien loads cpl", ctrl, 8'h8B);
    chk("R3 blocked while disabled", g_valid, 0);
    clr_req();
    wr(8'h9B);
    set_req(4, 1); #0.5;
    chk("R4 deeper source", g_idx, 4);
    do_ack();
    chk("R6 second nesting", ctrl, 8'h89);
    clr_req();
    do_ret();
    chk("R6 restore saved 3", ctrl, 8'h9B);
    do_ret();
    chk("R6 restore saved 7", ctrl, 8'h9F);
    do_ret();
    chk("R6 empty return idle", ctrl, 8'h9F);
  endtask

  task automatic t_ien_guard();
    set_req(1, 5); #0.5;
    wr(8'h8E);
    chk("R11 ien kept cpl written", ctrl, 8'h9E);
    clr_req();
    wr(8'h9F);
    chk("R2 restore", ctrl, 8'h9F);
  endtask

  task automatic t_concurrent();
    wr(8'h97);
    chk("R2 concurrent mode", ctrl, 8'h97);
    set_req(3, 2); #0.5;
    do_ack();
    chk("R5 concurrent ack", ctrl, 8'h82);
    clr_req();
    wr(8'h92);
    set_req(7, 1); #0.5;
    chk("R4 index 7", g_idx, 7);
    do_ack();
    chk("R7 second ack", ctrl, 8'h81);
    clr_req();
    do_ret();
    chk("R7 return to idle", ctrl, 8'h97);
  endtask

  task automatic t_top();
    wr(8'h9F);
    set_req(2, 3); #0.5;
    do_ack();
    clr_req();
    chk("R5 handler entry", ctrl, 8'h8B);
    top_req = 1'b1; step(); top_req = 1'b0;
    chk("R9 pending latched", ctrl, 8'hCB);
    chk("R10 bypass ien", g_valid, 1);
    chk("R4 top wins", g_top, 1);
    do_ack();
    chk("R9 top ack clears pending", ctrl, 8'h88);
    do_ret();
    chk("R6 restore after top", ctrl, 8'h9B);
    do_ret();
    chk("R8 final return", ctrl, 8'h9F);
  endtask

  task automatic t_top_mask();
    wr(8'hAF);
    chk("R2 mask mode on", ctrl, 8'hAF);
    top_req = 1'b1; step(); top_req = 1'b0;
    chk("R9 pending masked", ctrl, 8'hEF);
    chk("R10 masked no grant", g_valid, 0);
    wr(8'hFF);
    chk("R11 ien blocked by pending", ctrl, 8'hEF);
    wr(8'h8F);
    chk("R2 clear pending", ctrl, 8'h8F);
    wr(8'hCF);
    chk("R9 software set pending", ctrl, 8'hCF);
    chk("R10 software top grant", g_top, 1);
    do_ack();
    chk("R5 top ack level 0", ctrl, 8'h88);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R5 ack without grant ignored", ctrl, 8'h88);
    do_ret();
    chk("R6 restore idle", ctrl, 8'h9F);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; lvl = '0; top_req = 0; wr_en = 0;
    wr_data = '0; ack = 0; ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    t_reset();
    t_pick();
    t_nested();
    t_ien_guard();
    t_concurrent();
    t_top();
    t_top_mask();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule